// File: doc/BRIEF.md
# Scoreboard Function Unit Entry

This block is one hazard-tracking function unit of a scoreboard-style out-of-order core. An issued instruction (an operation code plus two source registers and one destination register) is accepted only when the unit is free. The unit records the three register numbers and exposes them to the dependency matrices. It then waits for its read-after-write hold to clear, requests the register file read port, and samples both operands on a one-cycle read grant.

The operands go to a compute pipeline that several units share. They carry this unit's identifier as a tag. Only a returning result whose tag matches is latched into the unit's private result latch. This happens even while a write-after-read hold from an earlier reader is still active, so the computation is not delayed by that hazard. The write request is raised only once that hold has cleared. On a single-cycle write grant the unit drives the result and its destination onto the write bus. The request drops in the next cycle to signal completion, and one cycle later the unit is free for a new issue.

The issue logic sees a busy flag and a separate flag for a result waiting to be written. An issue attempted while busy is discarded and reported with a one-cycle error pulse. The upstream logic is expected to stall in that case.

Top module: `fu_slot`

## Requirements
- R1: After reset, busy, readReq, pipeValid, writeReq, writePending and issueErr are all 0, and wrData is 0.
- R2: An issue pulse while idle makes busy 1 from the next cycle, and regSrcA, regSrcB and regDst then show the issued register numbers.
- R3: readReq is 1 only while the unit waits for operands and rawHold is 0. A goRead in a cycle where readReq is 0 has no effect: the unit keeps waiting for operands and pipeValid stays 0.
- R4: A goRead while readReq is 1 samples rdDataA and rdDataB. In the next cycle readReq is 0 and pipeValid is 1, with pipeA, pipeB, pipeOp and pipeTag (= UNIT_ID) carrying the sampled operands and the issued operation.
- R5: pipeValid stays 1 with stable operands until a cycle with pipeReady 1, and is 0 afterwards. A result whose resTag differs from UNIT_ID is ignored, and writePending stays 0.
- R6: A result with resTag equal to UNIT_ID, arriving after dispatch, is latched and sets writePending in the next cycle, whatever the level of warHold.
- R7: writeReq equals writePending AND NOT warHold in every cycle.
- R8: During a cycle with goWrite 1 and writeReq 1, wrData equals the latched result and wrDst equals the recorded destination. In every other cycle wrData is 0, including a goWrite that arrives while writeReq is 0, which leaves writePending at 1.
- R9: In the cycle after an accepted goWrite, writeReq is 0 and busy is still 1. In the cycle after that, busy is 0 and a new issue is accepted.
- R10: An issue pulse while busy is discarded: the recorded registers do not change, and issueErr is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue strobe |
| issueOp | input | OP_W | Operation code of the issued instruction |
| issueSrcA | input | REG_AW | First source register |
| issueSrcB | input | REG_AW | Second source register |
| issueDst | input | REG_AW | Destination register |
| rawHold | input | 1 | Read-after-write hold from the dependency matrix |
| goRead | input | 1 | One-cycle read grant |
| rdDataA | input | DATA_W | First operand from the register file |
| rdDataB | input | DATA_W | Second operand from the register file |
| pipeReady | input | 1 | Shared pipeline accepts the operands |
| resValid | input | 1 | Result returning from the shared pipeline |
| resTag | input | ID_W | Unit identifier attached to the result |
| resData | input | DATA_W | Result value |
| warHold | input | 1 | Write-after-read hold from the dependency matrix |
| goWrite | input | 1 | One-cycle write grant |
| busy | output | 1 | Unit holds an instruction |
| writePending | output | 1 | Result latched, not yet written |
| issueErr | output | 1 | Pulse: issue attempted while busy |
| regSrcA | output | REG_AW | Recorded first source register |
| regSrcB | output | REG_AW | Recorded second source register |
| regDst | output | REG_AW | Recorded destination register |
| readReq | output | 1 | Request for the register file read port |
| pipeValid | output | 1 | Operands offered to the shared pipeline |
| pipeOp | output | OP_W | Operation code sent to the pipeline |
| pipeA | output | DATA_W | First operand to the pipeline |
| pipeB | output | DATA_W | Second operand to the pipeline |
| pipeTag | output | ID_W | This unit's identifier sent with the operands |
| writeReq | output | 1 | Request for the register file write port |
| wrData | output | DATA_W | Result driven during the write grant |
| wrDst | output | REG_AW | Destination register for the write |

## Verification
The assertions check the handshake invariants in every cycle. A hold always masks its request, and each accepted grant removes its request in the next cycle. An accepted read also starts the pipeline offer, and a busy issue always produces the error pulse. The bench scenarios are the only way to show the data behaviour. They cover register capture, operand and result values, rejection of foreign result tags, and a result latched early while the write hold is active. They also cover spurious grants that must leave the state unchanged and the exact cycle in which busy falls.

// File: rtl/fu_slot_pkg.sv
package fu_slot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WAIT_READ  = 3'd1,
    ST_EXEC       = 3'd2,
    ST_WAIT_WRITE = 3'd3,
    ST_WRITE      = 3'd4
  } fuState_t;

  // Strobes from the control FSM to the datapath latches
  typedef struct packed {
    logic takeIssue;
    logic takeOps;
    logic takeRes;
    logic driveWrite;
  } fuStrobe_t;

endpackage

// File: rtl/fu_slot_ctrl.sv
module fu_slot_ctrl
  import fu_slot_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int UNIT_ID = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic            rawHold,
  input  logic            goRead,
  input  logic            pipeReady,
  input  logic            resValid,
  input  logic [ID_W-1:0] resTag,
  input  logic            warHold,
  input  logic            goWrite,
  output fuStrobe_t       strobe,
  output logic            busy,
  output logic            readReq,
  output logic            pipeValid,
  output logic            writeReq,
  output logic            writePending,
  output logic            issueErr
);

  localparam logic [ID_W-1:0] MY_TAG = ID_W'(UNIT_ID);

  fuState_t stateQ, stateD;
  logic     sentQ;
  logic     errQ;
  logic     resHit;

  assign busy         = (stateQ != ST_IDLE);
  assign readReq      = (stateQ == ST_WAIT_READ) && !rawHold;
  assign pipeValid    = (stateQ == ST_EXEC) && !sentQ;
  assign writePending = (stateQ == ST_WAIT_WRITE);
  assign writeReq     = writePending && !warHold;
  assign issueErr     = errQ;
  assign resHit       = resValid && (resTag == MY_TAG) && (stateQ == ST_EXEC) && sentQ;

  always_comb begin
    strobe.takeIssue  = (stateQ == ST_IDLE) && issueValid;
    strobe.takeOps    = readReq && goRead;
    strobe.takeRes    = resHit;
    strobe.driveWrite = writeReq && goWrite;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:       if (issueValid)        stateD = ST_WAIT_READ;
      ST_WAIT_READ:  if (strobe.takeOps)    stateD = ST_EXEC;
      ST_EXEC:       if (resHit)            stateD = ST_WAIT_WRITE;
      ST_WAIT_WRITE: if (strobe.driveWrite) stateD = ST_WRITE;
      ST_WRITE:                             stateD = ST_IDLE;
      default:                              stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      sentQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= issueValid && busy;
      if (strobe.takeOps)              sentQ <= 1'b0;
      else if (pipeValid && pipeReady) sentQ <= 1'b1;
    end
  end

  // R3
  raw_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    rawHold |-> !readReq);

  // R4
  read_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goRead && readReq) |=> (!readReq && pipeValid));

  // R7
  war_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    warHold |-> !writeReq);

  // R9
  write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goWrite && writeReq) |=> (!writeReq && busy));

  // R10
  busy_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && busy) |=> issueErr);

endmodule

// File: rtl/fu_slot_dp.sv
module fu_slot_dp
  import fu_slot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 5,
  parameter int OP_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fuStrobe_t         strobe,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [REG_AW-1:0] issueSrcA,
  input  logic [REG_AW-1:0] issueSrcB,
  input  logic [REG_AW-1:0] issueDst,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  input  logic [DATA_W-1:0] resData,
  output logic [OP_W-1:0]   opCode,
  output logic [REG_AW-1:0] srcA,
  output logic [REG_AW-1:0] srcB,
  output logic [REG_AW-1:0] dst,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] resQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opCode <= '0;
      srcA   <= '0;
      srcB   <= '0;
      dst    <= '0;
      opA    <= '0;
      opB    <= '0;
      resQ   <= '0;
    end else begin
      if (strobe.takeIssue) begin
        opCode <= issueOp;
        srcA   <= issueSrcA;
        srcB   <= issueSrcB;
        dst    <= issueDst;
      end
      if (strobe.takeOps) begin
        opA <= rdDataA;
        opB <= rdDataB;
      end
      if (strobe.takeRes) resQ <= resData;
    end
  end

  assign wrData = strobe.driveWrite ? resQ : '0;

  // R2
  reg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeIssue |=> ($stable(srcA) && $stable(srcB) && $stable(dst)));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeRes |=> $stable(resQ));

endmodule

// File: rtl/fu_slot.sv
module fu_slot
  import fu_slot_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_AW  = 5,
  parameter int OP_W    = 3,
  parameter int ID_W    = 2,
  parameter int UNIT_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [REG_AW-1:0] issueSrcA,
  input  logic [REG_AW-1:0] issueSrcB,
  input  logic [REG_AW-1:0] issueDst,
  input  logic              rawHold,
  input  logic              goRead,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  input  logic              pipeReady,
  input  logic              resValid,
  input  logic [ID_W-1:0]   resTag,
  input  logic [DATA_W-1:0] resData,
  input  logic              warHold,
  input  logic              goWrite,
  output logic              busy,
  output logic              writePending,
  output logic              issueErr,
  output logic [REG_AW-1:0] regSrcA,
  output logic [REG_AW-1:0] regSrcB,
  output logic [REG_AW-1:0] regDst,
  output logic              readReq,
  output logic              pipeValid,
  output logic [OP_W-1:0]   pipeOp,
  output logic [DATA_W-1:0] pipeA,
  output logic [DATA_W-1:0] pipeB,
  output logic [ID_W-1:0]   pipeTag,
  output logic              writeReq,
  output logic [DATA_W-1:0] wrData,
  output logic [REG_AW-1:0] wrDst
);

  fuStrobe_t strobe;

  fu_slot_ctrl #(.ID_W(ID_W), .UNIT_ID(UNIT_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .rawHold(rawHold),
    .goRead(goRead), .pipeReady(pipeReady), .resValid(resValid),
    .resTag(resTag), .warHold(warHold), .goWrite(goWrite), .strobe(strobe),
    .busy(busy), .readReq(readReq), .pipeValid(pipeValid),
    .writeReq(writeReq), .writePending(writePending), .issueErr(issueErr)
  );

  fu_slot_dp #(.DATA_W(DATA_W), .REG_AW(REG_AW), .OP_W(OP_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueOp(issueOp),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueDst(issueDst),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .resData(resData),
    .opCode(pipeOp), .srcA(regSrcA), .srcB(regSrcB), .dst(regDst),
    .opA(pipeA), .opB(pipeB), .wrData(wrData)
  );

  assign pipeTag = ID_W'(UNIT_ID);
  assign wrDst   = regDst;

endmodule

// File: tb/fu_slot_test.sv
module fu_slot_test;

  localparam int DW = 16, AW = 5, OW = 3, IW = 2, ID = 2;

  logic clk = 0, rstN = 0;
  logic issueValid = 0, rawHold = 0, goRead = 0, pipeReady = 0, resValid = 0;
  logic warHold = 0, goWrite = 0;
  logic [OW-1:0] issueOp = '0;
  logic [AW-1:0] issueSrcA = '0, issueSrcB = '0, issueDst = '0;
  logic [DW-1:0] rdDataA = '0, rdDataB = '0, resData = '0;
  logic [IW-1:0] resTag = '0;
  logic busy, writePending, issueErr, readReq, pipeValid, writeReq;
  logic [AW-1:0] regSrcA, regSrcB, regDst, wrDst;
  logic [OW-1:0] pipeOp;
  logic [DW-1:0] pipeA, pipeB, wrData;
  logic [IW-1:0] pipeTag;

  int nChk = 0, nFail = 0;
  bit done = 0;

  fu_slot #(.DATA_W(DW), .REG_AW(AW), .OP_W(OW), .ID_W(IW), .UNIT_ID(ID)) uut (.*);

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] calc(logic [OW-1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a ^ b;
      3'd3: return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] sA, sB, sD;
    logic [OW-1:0] op;
    logic [DW-1:0] a, b, expRes;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!busy && !readReq && !pipeValid && !writeReq && !writePending && !issueErr && wrData == 0,
        "R1", "reset outputs", {busy, readReq, pipeValid, writeReq, writePending, issueErr}, 0);
    rstN = 1;
    nxt();
    for (int n = 0; n < 400; n++) begin
      int rawCyc, stall, warCyc;
      bit tryBusy, foreign;
      sA = AW'($urandom); sB = AW'($urandom); sD = AW'($urandom);
      op = OW'($urandom);
      a = DW'($urandom); b = DW'($urandom);
      if (n == 0) begin a = '1; b = 1; op = 0; end
      rawCyc = $urandom_range(0, 3); stall = $urandom_range(0, 3);
      warCyc = $urandom_range(0, 3); tryBusy = ($urandom_range(0, 3) == 0) || n < 2;
      foreign = $urandom_range(0, 1) == 1;
      expRes = calc(op, a, b);
      // R9 free before issue
      chk(!busy, "R9", "idle before issue", busy, 0);
      issueValid = 1; issueOp = op; issueSrcA = sA; issueSrcB = sB; issueDst = sD;
      rawHold = (rawCyc > 0) || tryBusy;
      nxt();
      issueValid = 0;
      // R2 capture
      chk(busy && regSrcA == sA && regSrcB == sB && regDst == sD, "R2", "captured regs",
          {busy, regSrcA, regSrcB, regDst}, {1'b1, sA, sB, sD});
      if (tryBusy) begin
        issueValid = 1; issueSrcA = ~sA; issueSrcB = ~sB; issueDst = ~sD;
        nxt();
        issueValid = 0;
        // R10 discarded issue
        chk(issueErr, "R10", "error pulse", issueErr, 1);
        chk(regSrcA == sA && regSrcB == sB && regDst == sD, "R10", "regs kept",
            {regSrcA, regSrcB, regDst}, {sA, sB, sD});
        nxt();
        chk(!issueErr, "R10", "error one cycle", issueErr, 0);
      end
      for (int h = 0; h < rawCyc; h++) begin
        rawHold = 1; #1;
        // R3
        chk(!readReq, "R3", "readReq under hold", readReq, 0);
        goRead = 1; rdDataA = ~a; rdDataB = ~b;
        nxt();
        goRead = 0;
        chk(!pipeValid, "R3", "spurious goRead ignored", pipeValid, 0);
      end
      rawHold = 0; #1;
      chk(readReq, "R3", "readReq after hold", readReq, 1);
      goRead = 1; rdDataA = a; rdDataB = b;
      nxt();
      goRead = 0; rdDataA = '0; rdDataB = '0;
      // R4
      chk(!readReq && pipeValid, "R4", "read drop/offer", {readReq, pipeValid}, 2'b01);
      chk(pipeA == a && pipeB == b && pipeOp == op && pipeTag == IW'(ID), "R4", "pipe fields",
          {pipeA, pipeB}, {a, b});
      for (int s = 0; s < stall; s++) begin
        nxt();
        chk(pipeValid && pipeA == a && pipeB == b, "R5", "offer held", pipeValid, 1);
      end
      pipeReady = 1;
      nxt();
      pipeReady = 0;
      chk(!pipeValid, "R5", "offer dropped", pipeValid, 0);
      if (foreign) begin
        resValid = 1; resTag = IW'(ID + 1); resData = ~expRes;
        nxt();
        resValid = 0;
        chk(!writePending, "R5", "foreign tag ignored", writePending, 0);
      end
      warHold = (warCyc > 0);
      resValid = 1; resTag = IW'(ID); resData = expRes;
      nxt();
      resValid = 0; resData = '0;
      // R6
      chk(writePending, "R6", "early latch", writePending, 1);
      // R7
      chk(writeReq == !warHold, "R7", "request vs hold", writeReq, !warHold);
      for (int w = 0; w < warCyc; w++) begin
        warHold = 1; goWrite = 1; #1;
        chk(wrData == 0 && !writeReq, "R8", "spurious grant no data", wrData, 0);
        nxt();
        goWrite = 0;
        chk(writePending, "R8", "still pending", writePending, 1);
      end
      warHold = 0; #1;
      chk(writeReq, "R7", "request raised", writeReq, 1);
      chk(wrData == 0, "R8", "bus idle before grant", wrData, 0);
      goWrite = 1; #1;
      chk(wrData == expRes, "R8", "write data", wrData, expRes);
      chk(wrDst == sD, "R8", "write dst", wrDst, sD);
      nxt();
      goWrite = 0;
      // R9
      chk(!writeReq && busy, "R9", "drop then still busy", {writeReq, busy}, 2'b01);
      nxt();
      chk(!busy && wrData == 0, "R9", "released", busy, 0);
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule